// File: doc/BRIEF.md
# Parallel Flash Bus Timing Controller

This block connects a memory-mapped host port to an asynchronous parallel flash device. It produces the device chip select, a read strobe (output enable), a write strobe (write enable) and the device address, and it owns one side of a bidirectional data bus. Every device access has three timed phases. Chip select opens a setup interval. The strobe is then held active for a wait interval. A write can add a hold interval after its strobe ends, during which chip select stays active.

The phase lengths are parameters. Each length is given either in clock cycles or in ns, µs or ms. A time value becomes a whole number of cycles at elaboration, rounded up against the clock period parameter. Elaboration reports an error when setup plus wait plus board delay is too short to cover the device access time.

The host word can be wider than the device bus. In that case one host access becomes a series of narrow device accesses. For reads, the narrow results are assembled into one host word. For writes, the host word is delivered one device-width lane at a time. The host is stalled with a wait-request signal until the series is complete. Flash command sequences are left to software.

Top module: `flash_bus_timing_ctrl`

## Requirements
- R1: While reset is active and in the cycle after it, chip select, read strobe and write strobe are all high (inactive), the data bus is undriven (all Z), wait-request is high and read-data-valid is low.
- R2: A device access holds chip select low for exactly SETUP_CYC cycles before either strobe goes low.
- R3: A strobe stays low for exactly WAIT_CYC cycles per device access, and the two strobes are never low together or outside chip select.
- R4: After the write strobe rises, chip select stays low for exactly HOLD_CYC more cycles. A read releases chip select in the same cycle as its strobe.
- R5: A phase length in ns, µs or ms becomes ceil(value × unit / clock period) cycles, and a length in cycles is used unchanged. With a 20 ns clock, 30/70/20 ns give 2/4/1 cycles.
- R6: A host read of word A with 8-bit device lanes and a 32-bit host word performs 4 device reads in lane order 0,1,2,3 at device address A×4+lane. Host data bits [8k+7:8k] come from lane k.
- R7: Device writes also go in ascending lane order and put host bits [8k+7:8k] on the bus. The device address stays constant for the whole chip-select period.
- R8: A write performs a device access only for lanes that have a set byte enable (byte enable bit k covers lane k). A write with no enable bits set completes with wait-request low in the cycle it is first presented, with no chip-select activity.
- R9: Wait-request is low for exactly one cycle per access, the last cycle of the last device access. A read has (4·(SETUP_CYC+WAIT_CYC)+3) such earlier cycles; a write with n lanes has n·(SETUP_CYC+WAIT_CYC+HOLD_CYC)+n−1. Read-data-valid pulses for one cycle, in the next cycle, with the assembled word.
- R10: The block drives the data bus only while chip select is low during a write (setup through hold), and releases it at all other times.
- R11: Each chip-select low period contains exactly one strobe pulse; chip select goes high for at least one cycle between device accesses.
- R12: The timing check accepts a configuration only when (SETUP_CYC+WAIT_CYC)·clock period + board delay is strictly greater than the access time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | HOST_ADDR_W | Host word address |
| host_read | input | 1 | Host read request |
| host_write | input | 1 | Host write request |
| host_wdata | input | HOST_DATA_W | Host write word |
| host_be | input | HOST_DATA_W/8 | Host byte enables |
| host_waitreq | output | 1 | High stalls the host; low marks completion |
| host_rdata | output | HOST_DATA_W | Assembled read word |
| host_rvalid | output | 1 | One-cycle read data strobe |
| fl_addr | output | DEV_ADDR_W | Device address |
| fl_cs_n | output | 1 | Device chip select, active low |
| fl_oe_n | output | 1 | Device read strobe, active low |
| fl_we_n | output | 1 | Device write strobe, active low |
| fl_data | inout | DEV_DATA_W | Device data bus |

## Verification
Several things can happen in the same cycle on the last cycle of a read's last wait phase. The read strobe is about to rise, the final lane is captured, and wait-request drops. The bench issues read after read, each presented at the falling edge just after the previous completion. It then requires the assembled word with read-data-valid in the following cycle, and no extra chip-select period. A write with no byte enables completes in the very cycle the idle state accepts it. This case is provoked directly and judged by a zero-cycle stall and an unchanged count of device accesses.

// File: rtl/flash_bus_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the flash bus timing controller.
// Assumes every time value and the clock period are positive integers.
package flash_bus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    localparam int UNIT_CYCLES = 0;
    localparam int UNIT_NS     = 1;
    localparam int UNIT_US     = 2;
    localparam int UNIT_MS     = 3;

    // Converts a phase length to whole cycles, rounding up for time units.
    function automatic int to_cycles(input longint value, input int unit, input longint clk_ps);
        longint scale;
        case (unit)
            UNIT_NS: scale = 64'd1000;
            UNIT_US: scale = 64'd1000000;
            UNIT_MS: scale = 64'd1000000000;
            default: scale = 64'd0;
        endcase
        if (scale == 0) begin
            return int'(value);
        end
        return int'((value * scale + clk_ps - 1) / clk_ps);
    endfunction

    // True when setup plus wait plus board delay strictly exceeds the access time.
    function automatic bit timing_met(input int setup_cyc, input int wait_cyc, input longint clk_ps,
                                      input longint board_ps, input longint tacc_ps);
        return ((longint'(setup_cyc + wait_cyc) * clk_ps) + board_ps) > tacc_ps;
    endfunction

    // Clamps a cycle count to at least one.
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/flash_phase_timer.sv
`timescale 1ns/1ps
// Down-counter timing one phase of a device access.
// Loaded with (length - 1) when a phase is entered; expire is high on the phase's last cycle.
module flash_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, reloading on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/flash_lane_picker.sv
`timescale 1ns/1ps
// Picks the lowest pending device lane from a mask and flags when it is the last one.
// Assumes LANES >= 1; an empty mask yields lane 0 with any_lane low.
module flash_lane_picker #(
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input  logic [LANES-1:0]  pending,
    output logic [LANE_W-1:0] lane,
    output logic              any_lane,
    output logic              last_lane
);
    // Priority select of the lowest set bit.
    always_comb begin
        lane = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                lane = LANE_W'(i);
            end
        end
    end

    assign any_lane  = |pending;
    assign last_lane = any_lane && ((pending & (pending - 1'b1)) == '0);
endmodule

// File: rtl/flash_read_gather.sv
`timescale 1ns/1ps
// Collects device-width read results into one host word and raises a one-cycle valid.
// Assumes capture arrives with the lane index of the access in progress.
module flash_read_gather #(
    parameter int LANES  = 4,
    parameter int DEV_W  = 8,
    parameter int LANE_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [LANE_W-1:0]      lane,
    input  logic [DEV_W-1:0]       din,
    input  logic                   finish,
    output logic [LANES*DEV_W-1:0] word,
    output logic                   valid
);
    logic [LANES-1:0][DEV_W-1:0] slots_q;
    logic                        valid_q;

    // Store each captured lane in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else if (capture) begin
            slots_q[lane] <= din;
        end
    end

    // Pulse valid one cycle after the final lane is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= finish;
        end
    end

    assign word  = slots_q;
    assign valid = valid_q;
endmodule

// File: rtl/flash_bus_timing_ctrl.sv
`timescale 1ns/1ps
// Bridge from a stalling host port to an asynchronous parallel flash device.
// Each device access runs setup, strobe and (writes only) hold phases. A wide host word
// is split into device-width lanes issued lowest lane first. Assumes HOST_DATA_W is a
// power-of-two multiple of DEV_DATA_W, DEV_DATA_W is a multiple of 8, and the host holds
// its request stable until wait-request goes low.
module flash_bus_timing_ctrl
    import flash_bus_pkg::*;
#(
    parameter int DEV_ADDR_W     = 8,
    parameter int DEV_DATA_W     = 8,
    parameter int HOST_DATA_W    = 32,
    parameter int CLK_PERIOD_PS  = 20000,
    parameter int TIME_UNIT      = UNIT_NS,
    parameter int SETUP_TIME     = 30,
    parameter int WAIT_TIME      = 70,
    parameter int HOLD_TIME      = 20,
    parameter int ACCESS_TIME_PS = 90000,
    parameter int BOARD_DELAY_PS = 10000,
    localparam int LANES         = HOST_DATA_W / DEV_DATA_W,
    localparam int LANE_BITS     = $clog2(LANES),
    localparam int HOST_ADDR_W   = DEV_ADDR_W - LANE_BITS,
    localparam int HOST_BE_W     = HOST_DATA_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HOST_ADDR_W-1:0] host_addr,
    input  logic                   host_read,
    input  logic                   host_write,
    input  logic [HOST_DATA_W-1:0] host_wdata,
    input  logic [HOST_BE_W-1:0]   host_be,
    output logic                   host_waitreq,
    output logic [HOST_DATA_W-1:0] host_rdata,
    output logic                   host_rvalid,
    output logic [DEV_ADDR_W-1:0]  fl_addr,
    output logic                   fl_cs_n,
    output logic                   fl_oe_n,
    output logic                   fl_we_n,
    inout  wire  [DEV_DATA_W-1:0]  fl_data
);
    localparam int SETUP_CYC = to_cycles(SETUP_TIME, TIME_UNIT, CLK_PERIOD_PS);
    localparam int WAIT_CYC  = at_least_one(to_cycles(WAIT_TIME, TIME_UNIT, CLK_PERIOD_PS));
    localparam int HOLD_CYC  = to_cycles(HOLD_TIME, TIME_UNIT, CLK_PERIOD_PS);
    localparam int MAX_CYC   = (SETUP_CYC > WAIT_CYC)
                             ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                             : ((WAIT_CYC > HOLD_CYC) ? WAIT_CYC : HOLD_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int LANE_W    = (LANE_BITS > 0) ? LANE_BITS : 1;
    localparam int LANE_BYTES = DEV_DATA_W / 8;
    localparam bit TIMING_OK = timing_met(SETUP_CYC, WAIT_CYC, CLK_PERIOD_PS,
                                          BOARD_DELAY_PS, ACCESS_TIME_PS);

    // Elaboration check of the access-time budget.
    if (!TIMING_OK) begin : g_timing_violation
        $error("flash timing: setup + wait + board delay does not cover the access time");
    end

    phase_e                       phase_q, phase_d;
    logic                         is_wr_q;
    logic [HOST_ADDR_W-1:0]       addr_q;
    logic [LANES-1:0][DEV_DATA_W-1:0] wdata_q;
    logic [LANES-1:0]             pend_q, pend_d;
    logic [LANES-1:0]             wr_mask;
    logic [LANE_W-1:0]            cur_lane;
    logic                         any_lane;
    logic                         last_lane;
    logic                         accept;
    logic                         done;
    logic                         t_load;
    logic [CNT_W-1:0]             t_val;
    logic                         t_expire;
    logic                         cs_active;
    logic                         dq_oe;
    logic                         capture;
    logic                         finish_rd;
    logic [DEV_DATA_W-1:0]        fl_dout;

    // One enable bit per device lane: set when any byte in the lane is enabled.
    for (genvar l = 0; l < LANES; l++) begin : g_lane_mask
        assign wr_mask[l] = |host_be[l*LANE_BYTES +: LANE_BYTES];
    end

    flash_lane_picker #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_picker (
        .pending   (pend_q),
        .lane      (cur_lane),
        .any_lane  (any_lane),
        .last_lane (last_lane)
    );

    flash_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    // Phase sequencing: choose the next phase, timer load and completion.
    always_comb begin
        phase_d = phase_q;
        pend_d  = pend_q;
        t_load  = 1'b0;
        t_val   = '0;
        accept  = 1'b0;
        done    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (host_read || host_write) begin
                    if (!host_read && (wr_mask == '0)) begin
                        done = 1'b1;
                    end else begin
                        accept = 1'b1;
                        t_load = 1'b1;
                        if (SETUP_CYC > 0) begin
                            phase_d = PH_SETUP;
                            t_val   = CNT_W'(SETUP_CYC - 1);
                        end else begin
                            phase_d = PH_STROBE;
                            t_val   = CNT_W'(WAIT_CYC - 1);
                        end
                    end
                end
            end
            PH_GAP: begin
                t_load = 1'b1;
                if (SETUP_CYC > 0) begin
                    phase_d = PH_SETUP;
                    t_val   = CNT_W'(SETUP_CYC - 1);
                end else begin
                    phase_d = PH_STROBE;
                    t_val   = CNT_W'(WAIT_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (t_expire) begin
                    phase_d = PH_STROBE;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(WAIT_CYC - 1);
                end
            end
            PH_STROBE: begin
                if (t_expire) begin
                    if (is_wr_q && (HOLD_CYC > 0)) begin
                        phase_d = PH_HOLD;
                        t_load  = 1'b1;
                        t_val   = CNT_W'(HOLD_CYC - 1);
                    end else begin
                        pend_d  = pend_q & ~(LANES'(1) << cur_lane);
                        done    = last_lane;
                        phase_d = last_lane ? PH_IDLE : PH_GAP;
                    end
                end
            end
            PH_HOLD: begin
                if (t_expire) begin
                    pend_d  = pend_q & ~(LANES'(1) << cur_lane);
                    done    = last_lane;
                    phase_d = last_lane ? PH_IDLE : PH_GAP;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Latch the accepted request and retire lanes as they finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            pend_q  <= '0;
        end else if (accept) begin
            is_wr_q <= !host_read;
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            pend_q  <= host_read ? {LANES{1'b1}} : wr_mask;
        end else begin
            pend_q  <= pend_d;
        end
    end

    assign cs_active = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
    assign fl_cs_n   = !cs_active;
    assign fl_oe_n   = !((phase_q == PH_STROBE) && !is_wr_q);
    assign fl_we_n   = !((phase_q == PH_STROBE) && is_wr_q);
    assign dq_oe     = is_wr_q && cs_active;
    assign fl_dout   = wdata_q[cur_lane];
    assign fl_data   = dq_oe ? fl_dout : {DEV_DATA_W{1'bz}};

    // Device address: host word address with the lane index below it.
    if (LANE_BITS > 0) begin : g_addr_lanes
        assign fl_addr = {addr_q, cur_lane};
    end else begin : g_addr_single
        assign fl_addr = addr_q;
    end

    assign capture      = (phase_q == PH_STROBE) && t_expire && !is_wr_q;
    assign finish_rd    = done && (phase_q == PH_STROBE) && !is_wr_q;
    assign host_waitreq = !done;

    flash_read_gather #(
        .LANES  (LANES),
        .DEV_W  (DEV_DATA_W),
        .LANE_W (LANE_W)
    ) u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lane    (cur_lane),
        .din     (fl_data),
        .finish  (finish_rd),
        .word    (host_rdata),
        .valid   (host_rvalid)
    );

    // any_lane is informative only; an accepted access always has a pending lane.
    logic unused_any;
    assign unused_any = any_lane;
endmodule

// File: rtl/flash_bus_timing_chk.sv
`timescale 1ns/1ps
// Property checker bound to the flash bus timing controller.
// Observes the device pins, the bus drive enable and the host handshake.
module flash_bus_timing_chk #(
    parameter int DEV_ADDR_W = 8,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fl_cs_n,
    input logic                  fl_oe_n,
    input logic                  fl_we_n,
    input logic [DEV_ADDR_W-1:0] fl_addr,
    input logic                  dq_oe,
    input logic                  host_waitreq,
    input logic                  host_rvalid
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (fl_cs_n && fl_oe_n && fl_we_n && !dq_oe && !host_rvalid));

    if (SETUP_CYC > 0) begin : g_setup
        // R2
        setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fl_cs_n) |-> (fl_oe_n && fl_we_n));
    end

    // R3
    read_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_cs_n));

    // R3
    write_strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_cs_n);

    if (HOLD_CYC > 0) begin : g_hold
        // R4
        write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fl_we_n) |-> !fl_cs_n);
    end

    // R7
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_cs_n && $past(!fl_cs_n)) |-> $stable(fl_addr));

    // R10
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!fl_cs_n && fl_oe_n));

    // R9
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R9
    rvalid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(!host_waitreq));
endmodule

bind flash_bus_timing_ctrl flash_bus_timing_chk #(
    .DEV_ADDR_W (DEV_ADDR_W),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fl_cs_n      (fl_cs_n),
    .fl_oe_n      (fl_oe_n),
    .fl_we_n      (fl_we_n),
    .fl_addr      (fl_addr),
    .dq_oe        (dq_oe),
    .host_waitreq (host_waitreq),
    .host_rvalid  (host_rvalid)
);

// File: tb/flash_bus_timing_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for the flash bus timing controller: a byte-wide device model, a pin monitor
// timing every phase, and directed plus seeded random host traffic.
module flash_bus_timing_ctrl_bench;
    import flash_bus_pkg::*;

    localparam int CLK_PS  = 20000;
    localparam int SET_NS  = 30;
    localparam int WAIT_NS = 70;
    localparam int HOLD_NS = 20;

    function automatic int ceil_div(input longint a, input longint b);
        return int'((a + b - 1) / b);
    endfunction

    localparam int EXP_S = (SET_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_W = (WAIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int EXP_H = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  host_addr = '0;
    logic        host_read = 1'b0;
    logic        host_write = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_waitreq;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [7:0]  fl_addr;
    logic        fl_cs_n, fl_oe_n, fl_we_n;
    wire  [7:0]  fl_data;

    always #10 clk = ~clk;

    flash_bus_timing_ctrl #(
        .DEV_ADDR_W (8),
        .DEV_DATA_W (8),
        .HOST_DATA_W(32),
        .CLK_PERIOD_PS(CLK_PS),
        .TIME_UNIT  (UNIT_NS),
        .SETUP_TIME (SET_NS),
        .WAIT_TIME  (WAIT_NS),
        .HOLD_TIME  (HOLD_NS),
        .ACCESS_TIME_PS(90000),
        .BOARD_DELAY_PS(10000)
    ) u_flash_bus_timing_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_read(host_read), .host_write(host_write),
        .host_wdata(host_wdata), .host_be(host_be), .host_waitreq(host_waitreq),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .fl_addr(fl_addr), .fl_cs_n(fl_cs_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_data(fl_data)
    );

    logic [7:0] dev_mem [0:255];
    logic [7:0] exp_mem [0:255];

    assign fl_data = (!fl_cs_n && !fl_oe_n) ? dev_mem[fl_addr] : 8'hzz;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Operation context shared with the monitor.
    bit          op_wr = 1'b0;
    logic [5:0]  op_addr = '0;
    logic [31:0] op_wdata = '0;
    logic [3:0]  op_be = '0;
    int          sub_cnt = 0;
    int          prev_lane = -1;

    // Monitor state.
    bit         prev_cs = 1'b1, prev_st = 1'b1;
    int         cs_cnt = 0, st_cnt = 0, hold_cnt = 0, pulses = 0;
    bit         moved = 1'b0, was_wr = 1'b0;
    logic [7:0] base_addr = '0;
    int         lane_i;

    // Device write capture.
    always @(negedge clk) begin
        if (!fl_cs_n && !fl_we_n) dev_mem[fl_addr] = fl_data;
    end

    // Pin monitor: phase lengths, lane order, bus drive window.
    always @(negedge clk) begin
        if (rst_n) begin
            bit strobe_n;
            strobe_n = fl_oe_n && fl_we_n;
            if (!fl_cs_n) begin
                if (prev_cs) begin
                    cs_cnt = 0; pulses = 0; base_addr = fl_addr; moved = 1'b0;
                    hold_cnt = 0; st_cnt = 0; was_wr = 1'b0;
                end
                if (fl_addr != base_addr) moved = 1'b1;
                if (!strobe_n) begin
                    if (prev_st) begin
                        check(cs_cnt == EXP_S, "R2", "setup cycles", cs_cnt, EXP_S);
                        pulses++; st_cnt = 0; sub_cnt++; was_wr = !fl_we_n;
                        lane_i = int'(fl_addr[1:0]);
                        check(lane_i > prev_lane, "R6", "lane order", lane_i, prev_lane + 1);
                        check(fl_addr[7:2] == op_addr, "R6", "word address", fl_addr[7:2], op_addr);
                        if (!fl_we_n) begin
                            check(op_be[lane_i], "R8", "disabled lane written", lane_i, -1);
                            check(fl_data == op_wdata[lane_i*8 +: 8], "R7", "write lane data",
                                  fl_data, op_wdata[lane_i*8 +: 8]);
                        end
                        prev_lane = lane_i;
                    end
                    st_cnt++;
                end else if (pulses > 0) begin
                    hold_cnt++;
                end
                cs_cnt++;
            end
            if (!prev_st && strobe_n) check(st_cnt == EXP_W, "R3", "strobe width", st_cnt, EXP_W);
            if (fl_cs_n && !prev_cs) begin
                check(hold_cnt == (was_wr ? EXP_H : 0), "R4", "hold cycles", hold_cnt,
                      was_wr ? EXP_H : 0);
                check(pulses == 1, "R11", "strobes per chip select", pulses, 1);
                check(!moved, "R7", "address moved in chip select", moved, 0);
            end
            if (fl_oe_n) begin
                if (!fl_cs_n && op_wr) begin
                    check(!$isunknown(fl_data), "R10", "bus not driven during write", 0, 1);
                end else begin
                    check(fl_data === 8'hzz, "R10", "bus driven outside write", fl_data, 0);
                end
            end
            prev_cs = fl_cs_n;
            prev_st = strobe_n;
        end
    end

    function automatic int lanes_of(input logic [3:0] be);
        return int'(be[0]) + int'(be[1]) + int'(be[2]) + int'(be[3]);
    endfunction

    task automatic do_read(input logic [5:0] a);
        int cyc;
        logic [31:0] exp_word;
        for (int k = 0; k < 4; k++) exp_word[k*8 +: 8] = exp_mem[{a, 2'(k)}];
        @(negedge clk);
        op_wr = 1'b0; op_addr = a; sub_cnt = 0; prev_lane = -1;
        host_addr = a; host_read = 1'b1;
        cyc = 0;
        #1;
        while (host_waitreq) begin
            @(negedge clk); #1; cyc++;
        end
        check(cyc == 4 * (EXP_S + EXP_W) + 3, "R9", "read stall cycles", cyc, 4 * (EXP_S + EXP_W) + 3);
        @(negedge clk);
        host_read = 1'b0;
        check(host_rvalid == 1'b1, "R9", "rvalid after read", host_rvalid, 1);
        check(host_rdata == exp_word, "R6", "assembled read word", host_rdata, exp_word);
        check(sub_cnt == 4, "R6", "device reads per word", sub_cnt, 4);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        int cyc, n, exp_cyc;
        n = lanes_of(be);
        exp_cyc = (n == 0) ? 0 : n * (EXP_S + EXP_W + EXP_H) + n - 1;
        for (int k = 0; k < 4; k++) if (be[k]) exp_mem[{a, 2'(k)}] = d[k*8 +: 8];
        @(negedge clk);
        op_wr = 1'b1; op_addr = a; op_wdata = d; op_be = be; sub_cnt = 0; prev_lane = -1;
        host_addr = a; host_wdata = d; host_be = be; host_write = 1'b1;
        cyc = 0;
        #1;
        while (host_waitreq) begin
            @(negedge clk); #1; cyc++;
        end
        check(cyc == exp_cyc, (n == 0) ? "R8" : "R9", "write stall cycles", cyc, exp_cyc);
        @(negedge clk);
        host_write = 1'b0;
        op_wr = 1'b0;
        check(sub_cnt == n, "R8", "device writes issued", sub_cnt, n);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F1A5));
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fl_cs_n && fl_oe_n && fl_we_n, "R1", "strobes idle in reset", {fl_cs_n, fl_oe_n, fl_we_n}, 7);
        check(fl_data === 8'hzz, "R1", "bus released in reset", fl_data, 0);
        check(host_waitreq && !host_rvalid, "R1", "handshake in reset", {host_waitreq, host_rvalid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(fl_cs_n && fl_oe_n && fl_we_n && !host_rvalid, "R1", "idle after reset",
              {fl_cs_n, fl_oe_n, fl_we_n, host_rvalid}, 14);

        // R5 unit conversion, R12 timing budget.
        check(to_cycles(SET_NS, UNIT_NS, CLK_PS) == ceil_div(SET_NS * 1000, CLK_PS), "R5", "ns setup",
              to_cycles(SET_NS, UNIT_NS, CLK_PS), ceil_div(SET_NS * 1000, CLK_PS));
        check(to_cycles(WAIT_NS, UNIT_NS, CLK_PS) == 4, "R5", "ns wait", to_cycles(WAIT_NS, UNIT_NS, CLK_PS), 4);
        check(to_cycles(1, UNIT_US, CLK_PS) == 50, "R5", "us", to_cycles(1, UNIT_US, CLK_PS), 50);
        check(to_cycles(1, UNIT_MS, CLK_PS) == 50000, "R5", "ms", to_cycles(1, UNIT_MS, CLK_PS), 50000);
        check(to_cycles(7, UNIT_CYCLES, CLK_PS) == 7, "R5", "cycles", to_cycles(7, UNIT_CYCLES, CLK_PS), 7);
        check(timing_met(2, 4, CLK_PS, 10000, 90000) == 1'b1, "R12", "budget met", 0, 1);
        check(timing_met(1, 2, CLK_PS, 0, 60000) == 1'b0, "R12", "equal budget rejected", 1, 0);

        // Directed corners.
        do_read(6'd0);
        do_read(6'd63);
        do_write(6'd5, 32'hDEADBEEF, 4'b1111);
        do_read(6'd5);
        do_write(6'd6, 32'h11223344, 4'b0100);
        do_read(6'd6);
        do_write(6'd7, 32'hA5C3E1F0, 4'b1001);
        do_read(6'd7);
        do_write(6'd8, 32'hFFFFFFFF, 4'b0000);
        do_read(6'd8);

        // Seeded random traffic.
        for (int i = 0; i < 60; i++) begin
            logic [5:0] a;
            a = 6'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1) do_write(a, $urandom(), 4'($urandom()));
            else do_read(a);
        end

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule